// File: doc/BRIEF.md
# Windowed Modular Exponentiation Engine

This block raises an unsigned base to an unsigned exponent modulo an odd modulus, all W bits wide (32 by default), and returns `base^exp mod mod`. A one-cycle start pulse while the engine is idle captures the three operands. The engine then fills a table of the base's powers 1 through 15 modulo the modulus. Next it walks the exponent four bits at a time, starting at the most significant window. For each window it squares the running value four times and then, if the window is not zero, multiplies by the table entry that the window selects. All products come from one bit-serial multiplier that interleaves shift-and-add with reduction.

The caller must keep the modulus above 1 and the base below the modulus. Each finished run raises a one-cycle done flag. The result stays on its port until the next run completes. The run time depends only on the width and on how many exponent windows are nonzero, so a host can predict it exactly.

Top module: `modexp_engine`

## Requirements
- R1: While reset is held and after its release, `done_o` is 0 and `result_o` is 0 until the first run completes.
- R2: For a nonzero exponent, the completed run returns base^exp mod mod, given mod > 1, mod odd and base < mod.
- R3: An exponent of 0 returns 1, and `done_o` rises in the cycle right after the start edge.
- R4: For a nonzero exponent, `done_o` is first high (14 + 4·(W/4) + Z)·(W+2) cycles after the start edge, where Z is the number of nonzero 4-bit exponent windows. With W = 32 this is (46 + Z)·34.
- R5: An exponent window of value 0 costs four squarings and no table multiply, which saves W+2 cycles per zero window compared with a nonzero one. The result is still correct.
- R6: `done_o` is high for exactly one cycle per run. The only exception is a zero-exponent start issued in that same cycle.
- R7: A start pulse that arrives while a run is in progress is ignored. The ongoing result and its timing are unchanged.
- R8: The operands are captured at the start edge. Changing the inputs afterwards does not affect the run.
- R9: `result_o` changes only together with a `done_o` pulse and otherwise holds its value.
- R10: An exponent of 1 returns the base itself, and a base of 0 with a nonzero exponent returns 0.
- R11: An all-ones exponent, with every window equal to 15, gives the correct result using the last table entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| base_i | input | W | Base, must be below the modulus |
| exp_i | input | W | Exponent |
| mod_i | input | W | Odd modulus greater than 1 |
| result_o | output | W | Result of the last completed run |
| done_o | output | 1 | One-cycle completion flag |

## Verification
Every run has a completion time that can be worked out in advance. A zero exponent finishes on the start edge itself. Any other exponent finishes after (46 + Z)·34 cycles at W = 32, where Z counts the nonzero windows. The bench therefore computes the expected cycle count from the exponent before each run. It counts falling edges from the start edge until `done_o` is seen, and it compares both the value and the count. One falling edge later it checks that the flag has dropped. A few cycles after that it checks that the result has held, and it also confirms that a start raised mid-run does not shift the finish time.

// File: rtl/modexp_pkg.sv
package modexp_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_TABLE  = 2'd1,
      PH_SQUARE = 2'd2,
      PH_MULT   = 2'd3
   } phase_e;
endpackage

// File: rtl/modexp_mulmod.sv
// Bit-serial interleaved modular multiplier: prod = a*b mod n.
// Operands must be below n. One bit of a per cycle, MSB first.
module modexp_mulmod #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] n_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] prod_o
);
   localparam int PW = W + 2;            // partial sum reaches < 3n
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  a_sh;
   logic [W-1:0]  b_q;
   logic [W-1:0]  n_q;
   logic [PW-1:0] p_q;
   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          done_q;

   logic [PW-1:0] dbl, sum, red1, red2, n_ext;

   always_comb begin
      n_ext = {2'b00, n_q};
      dbl   = {p_q[PW-2:0], 1'b0};
      sum   = dbl + (a_sh[W-1] ? {2'b00, b_q} : '0);
      red1  = (sum  >= n_ext) ? sum  - n_ext : sum;
      red2  = (red1 >= n_ext) ? red1 - n_ext : red1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_sh   <= '0;
         b_q    <= '0;
         n_q    <= '0;
         p_q    <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go_i && !busy_q) begin
            a_sh   <= a_i;
            b_q    <= b_i;
            n_q    <= n_i;
            p_q    <= '0;
            cnt_q  <= CW'(W);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            p_q   <= red2;
            a_sh  <= {a_sh[W-2:0], 1'b0};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;
   assign prod_o = p_q[W-1:0];
endmodule

// File: rtl/modexp_powtab.sv
// Table of base powers. Entry 0 is the constant 1, the rest are registers.
module modexp_powtab #(
   parameter int W   = 32,
   parameter int WIN = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we_i,
   input  logic [WIN-1:0] waddr_i,
   input  logic [W-1:0]   wdata_i,
   input  logic [WIN-1:0] raddr_i,
   output logic [W-1:0]   rdata_o
);
   localparam int DEPTH = 1 << WIN;

   logic [DEPTH*W-1:0] flat;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      if (g == 0) begin : g_one
         assign flat[g*W +: W] = W'(1);
      end else begin : g_reg
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (we_i && waddr_i == WIN'(g))
               q <= wdata_i;
         end
         assign flat[g*W +: W] = q;
      end
   end

   assign rdata_o = flat[raddr_i*W +: W];
endmodule

// File: rtl/modexp_ctrl.sv
// Sequencer: operand capture, table fill, per-window square/multiply.
module modexp_ctrl
   import modexp_pkg::*;
#(
   parameter int W   = 32,
   parameter int WIN = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [W-1:0]   base_i,
   input  logic [W-1:0]   exp_i,
   input  logic [W-1:0]   mod_i,
   input  logic           mul_done_i,
   input  logic [W-1:0]   prod_i,
   input  logic [W-1:0]   tab_rd_i,
   output logic           mul_go_o,
   output logic [W-1:0]   op_a_o,
   output logic [W-1:0]   op_b_o,
   output logic [W-1:0]   mod_q_o,
   output logic           tab_we_o,
   output logic [WIN-1:0] tab_waddr_o,
   output logic [W-1:0]   tab_wdata_o,
   output logic [WIN-1:0] tab_raddr_o,
   output logic           busy_o,
   output logic           done_o,
   output logic [W-1:0]   result_o
);
   localparam int NDIG = W / WIN;
   localparam int DEPTH = 1 << WIN;
   localparam int DW   = $clog2(NDIG);
   localparam int SW   = $clog2(WIN);
   localparam logic [WIN-1:0] LAST_ENT = WIN'(DEPTH - 1);
   localparam logic [SW-1:0]  LAST_SQ  = SW'(WIN - 1);

   phase_e         ph_q;
   logic [W-1:0]   m_q, e_q, n_q, acc_q, res_q;
   logic [WIN-1:0] ent_q;
   logic [DW-1:0]  dig_q;
   logic [SW-1:0]  sq_q;
   logic           go_q, done_q;
   logic [WIN-1:0] digit;
   logic           idle_go;

   always_comb begin
      digit   = e_q[dig_q*WIN +: WIN];
      idle_go = (ph_q == PH_IDLE) && start_i;
      tab_raddr_o = (ph_q == PH_TABLE) ? ent_q - 1'b1 : digit;
      op_a_o = (ph_q == PH_TABLE) ? tab_rd_i : acc_q;
      case (ph_q)
         PH_TABLE: op_b_o = m_q;
         PH_MULT:  op_b_o = tab_rd_i;
         default:  op_b_o = acc_q;
      endcase
      tab_we_o    = (idle_go && exp_i != '0) || (ph_q == PH_TABLE && mul_done_i);
      tab_waddr_o = (ph_q == PH_TABLE) ? ent_q : WIN'(1);
      tab_wdata_o = (ph_q == PH_TABLE) ? prod_i : base_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         m_q    <= '0;
         e_q    <= '0;
         n_q    <= '0;
         acc_q  <= '0;
         res_q  <= '0;
         ent_q  <= '0;
         dig_q  <= '0;
         sq_q   <= '0;
         go_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         go_q   <= 1'b0;
         done_q <= 1'b0;
         case (ph_q)
            PH_IDLE: begin
               if (start_i) begin
                  m_q   <= base_i;
                  e_q   <= exp_i;
                  n_q   <= mod_i;
                  acc_q <= W'(1);
                  if (exp_i == '0) begin
                     res_q  <= W'(1);
                     done_q <= 1'b1;
                  end else begin
                     ph_q  <= PH_TABLE;
                     ent_q <= WIN'(2);
                     go_q  <= 1'b1;
                  end
               end
            end
            PH_TABLE: begin
               if (mul_done_i) begin
                  go_q <= 1'b1;
                  if (ent_q == LAST_ENT) begin
                     ph_q  <= PH_SQUARE;
                     sq_q  <= '0;
                     dig_q <= DW'(NDIG - 1);
                  end else begin
                     ent_q <= ent_q + 1'b1;
                  end
               end
            end
            PH_SQUARE: begin
               if (mul_done_i) begin
                  acc_q <= prod_i;
                  if (sq_q != LAST_SQ) begin
                     sq_q <= sq_q + 1'b1;
                     go_q <= 1'b1;
                  end else if (digit != '0) begin
                     ph_q <= PH_MULT;
                     go_q <= 1'b1;
                  end else if (dig_q == '0) begin
                     ph_q   <= PH_IDLE;
                     res_q  <= prod_i;
                     done_q <= 1'b1;
                  end else begin
                     dig_q <= dig_q - 1'b1;
                     sq_q  <= '0;
                     go_q  <= 1'b1;
                  end
               end
            end
            PH_MULT: begin
               if (mul_done_i) begin
                  acc_q <= prod_i;
                  if (dig_q == '0) begin
                     ph_q   <= PH_IDLE;
                     res_q  <= prod_i;
                     done_q <= 1'b1;
                  end else begin
                     ph_q  <= PH_SQUARE;
                     dig_q <= dig_q - 1'b1;
                     sq_q  <= '0;
                     go_q  <= 1'b1;
                  end
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign mul_go_o = go_q;
   assign mod_q_o  = n_q;
   assign busy_o   = (ph_q != PH_IDLE);
   assign done_o   = done_q;
   assign result_o = res_q;
endmodule

// File: rtl/modexp_engine.sv
module modexp_engine #(
   parameter int W   = 32,
   parameter int WIN = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] base_i,
   input  logic [W-1:0] exp_i,
   input  logic [W-1:0] mod_i,
   output logic [W-1:0] result_o,
   output logic         done_o
);
   if (WIN < 2) begin : g_bad_win
      $error("modexp_engine: WIN must be at least 2");
   end
   if (W % WIN != 0) begin : g_bad_div
      $error("modexp_engine: W must be a multiple of WIN");
   end
   if (W / WIN < 2) begin : g_bad_ndig
      $error("modexp_engine: need at least two exponent windows");
   end

   logic           mul_go, mul_busy, mul_done;
   logic [W-1:0]   op_a, op_b, prod, n_q, tab_rd, tab_wdata;
   logic           tab_we, busy;
   logic [WIN-1:0] tab_waddr, tab_raddr;

   modexp_ctrl #(.W(W), .WIN(WIN)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .base_i      (base_i),
      .exp_i       (exp_i),
      .mod_i       (mod_i),
      .mul_done_i  (mul_done),
      .prod_i      (prod),
      .tab_rd_i    (tab_rd),
      .mul_go_o    (mul_go),
      .op_a_o      (op_a),
      .op_b_o      (op_b),
      .mod_q_o     (n_q),
      .tab_we_o    (tab_we),
      .tab_waddr_o (tab_waddr),
      .tab_wdata_o (tab_wdata),
      .tab_raddr_o (tab_raddr),
      .busy_o      (busy),
      .done_o      (done_o),
      .result_o    (result_o)
   );

   modexp_mulmod #(.W(W)) u_mul (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (mul_go),
      .a_i    (op_a),
      .b_i    (op_b),
      .n_i    (n_q),
      .busy_o (mul_busy),
      .done_o (mul_done),
      .prod_o (prod)
   );

   modexp_powtab #(.W(W), .WIN(WIN)) u_tab (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (tab_we),
      .waddr_i (tab_waddr),
      .wdata_i (tab_wdata),
      .raddr_i (tab_raddr),
      .rdata_o (tab_rd)
   );
endmodule

// File: rtl/modexp_engine_chk.sv
module modexp_engine_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic [W-1:0] exp_i,
   input logic [W-1:0] result_o,
   input logic         done_o,
   input logic         busy,
   input logic [W-1:0] n_q
);
   // R6: a single-cycle flag unless a zero-exponent start restarts it
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !(start_i && exp_i == '0 && !busy)) |=> !done_o);

   // R2: any delivered result is reduced below the captured modulus
   a_r2_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (result_o < n_q));

   // R9: the result port moves only with a completion flag
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_o) |-> done_o);

   // R3: zero exponent answers 1 on the next cycle
   a_r3_zero_exp: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start_i && exp_i == '0) |=> (done_o && result_o == W'(1)));

   // R7: a run begins only from a start pulse
   a_r7_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start_i));

   // R4: a run always ends with a completion flag
   a_r4_end_flags_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_o);
endmodule

bind modexp_engine modexp_engine_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .exp_i    (exp_i),
   .result_o (result_o),
   .done_o   (done_o),
   .busy     (busy),
   .n_q      (n_q)
);

// File: tb/sim_modexp_engine.sv
module sim_modexp_engine;
   localparam int W      = 32;
   localparam int WIN    = 4;
   localparam int NDIG   = W / WIN;
   localparam int TABOPS = (1 << WIN) - 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] base = '0, expo = '0, modu = '0;
   logic [W-1:0] result;
   logic         done;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   always #4 clk = ~clk;

   modexp_engine #(.W(W), .WIN(WIN)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .base_i   (base),
      .exp_i    (expo),
      .mod_i    (modu),
      .result_o (result),
      .done_o   (done)
   );

   function automatic logic [W-1:0] ref_pow(logic [W-1:0] m, logic [W-1:0] e,
                                            logic [W-1:0] n);
      logic [63:0] r, b, n64;
      n64 = {32'd0, n};
      r = 64'd1;
      b = {32'd0, m} % n64;
      for (int i = 0; i < W; i++) begin
         if (e[i]) r = (r * b) % n64;
         b = (b * b) % n64;
      end
      return r[W-1:0];
   endfunction

   function automatic int exp_lat(logic [W-1:0] e);
      int nz = 0;
      if (e == '0) return 1;
      for (int i = 0; i < NDIG; i++)
         if (e[i*WIN +: WIN] != '0) nz++;
      return (TABOPS + WIN * NDIG + nz) * (W + 2) + 1;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // One run: vtag names the value check, ltag the timing check.
   task automatic run(logic [W-1:0] m, logic [W-1:0] e, logic [W-1:0] n,
                      string vtag, string ltag, bit disturb, bit restart);
      int cnt = 0;
      bit got = 1'b0;
      logic [W-1:0] held;
      @(negedge clk);
      base = m; expo = e; modu = n; start = 1'b1;
      while (!got && cnt < 5000) begin
         @(negedge clk);
         cnt++;
         if (cnt == 1) begin
            start = 1'b0;
            if (disturb) begin
               base = $urandom; expo = $urandom; modu = $urandom;
            end
         end
         if (restart && cnt == 40) begin
            start = 1'b1; base = 32'd3; expo = 32'd0; modu = 32'd7;
         end
         if (cnt == 41) start = 1'b0;
         if (done) got = 1'b1;
      end
      start = 1'b0;
      check(vtag, result, ref_pow(m, e, n));
      check(ltag, cnt, exp_lat(e));
      held = result;
      @(negedge clk);
      check("R6 done falls", done, 0);
      repeat (3) @(negedge clk);
      check("R9 result held", result, held);
   endtask

   initial begin
      #(8 * 190000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check("R1 done in reset", done, 0);
      check("R1 result in reset", result, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 done after reset", done, 0);
      check("R1 result after reset", result, 0);

      run(32'd1234567, 32'd0, 32'hFFFF_FFFB, "R3 zero exp", "R3 latency", 0, 0);
      run(32'hDEAD_BEE5, 32'd1, 32'hFFFF_FFFB, "R10 exp one", "R4 latency", 0, 0);
      run(32'd0, 32'd77, 32'd1001, "R10 zero base", "R4 latency", 0, 0);
      run(32'h1234_5679, 32'hFFFF_FFFF, 32'hF123_4567, "R11 all ones", "R4 latency", 0, 0);
      run(32'd5, 32'h1000_0001, 32'd65537, "R5 zero windows", "R5 latency", 0, 0);
      run(32'hABCD_0123, 32'h00F0_0000, 32'hC000_0001, "R5 one window", "R5 latency", 0, 0);
      run(32'd2, 32'd100, 32'd3, "R2 small mod 3", "R4 latency", 0, 0);
      run(32'd4, 32'hFFFF_FFFF, 32'd5, "R2 small mod 5", "R4 latency", 0, 0);
      run(32'hFFFF_FFFE, 32'd65537, 32'hFFFF_FFFF, "R2 max mod", "R4 latency", 0, 0);
      run(32'h0BAD_F00D, 32'h0001_0003, 32'hFEDC_BA99, "R8 inputs latched", "R8 latency", 1, 0);
      run(32'h7777_7777, 32'h8000_0000, 32'hE000_0003, "R7 start ignored", "R7 latency", 0, 1);

      for (int k = 0; k < 30; k++) begin
         logic [W-1:0] n, m, e;
         if (k % 3 == 0) n = (($urandom % 250) + 3) | 32'd1;
         else            n = $urandom | 32'h8000_0001;
         m = $urandom % n;
         e = $urandom;
         if (k % 5 == 0) e = e & 32'h0F0F_00F0;
         run(m, e, n, "R2 random", "R4 random latency", 0, 0);
      end
      summary();
   end
endmodule